// File: doc/BRIEF.md
# Burst-of-Four Split-Port Synchronous SRAM

This block is a synthesizable, cycle-accurate model of a static RAM that has separate write-data and read-data buses and moves data in fixed bursts of four words. It runs on a beat clock at twice the command rate. The `kphase` input marks which beats are command beats (high) and which are the half-period beats between them (low). On each command beat the block samples an active-low read strobe, an active-low write strobe and one shared burst address. The two lowest word-index bits are generated inside the block and count 0, 1, 2, 3 across the four beats of a burst.

The read port and the write port each run their own burst sequencer. A read and a write can therefore overlap in time. Whether a command is taken depends on what the previous command beat loaded, so a port can be restarted at most every second command beat. Each write beat carries its own active-low byte-lane enables. The storage is a small register array whose size is set by parameters.

Top module: `sq4_sram`

## Requirements
- R1: Strobes and address are acted on only at beat edges where `kphase`=1. Strobes that are low at a `kphase`=0 edge have no effect.
- R2: At a command edge where `rd_n`=1 and `wr_n`=1, no operation starts and the remembered previous command becomes idle.
- R3: At a command edge, `rd_n`=0 starts a read unless the previous command edge loaded a read. A read ignored this way loads idle.
- R4: At a command edge, `wr_n`=0 together with `rd_n`=1 starts a write unless the previous command edge loaded a write. When both strobes are low, the command is treated as a read.
- R5: Beat k (k = 0..3) of a burst at burst address A accesses word index 4·A + k.
- R6: For a write accepted at edge n, `wdata` is stored at edges n+2, n+3, n+4 and n+5.
- R7: For a read accepted at edge n, `rd_data` carries words 0..3 of the burst after edges n+2..n+5. `rd_valid` is 1 during exactly those four beats.
- R8: `be_n` bit i, when low on a write beat, stores `wdata` bits [9i+8:9i]. When that bit is high, the lane keeps its old content.
- R9: A command accepted while the same port's earlier burst is still running does not shorten that burst. Its own burst follows directly after it, and bursts on one port never disturb the other port.
- R10: A read returns the data of every write accepted at an earlier command edge, including a write whose beats are still in progress.
- R11: After reset the array holds zero and `rd_valid` is 0. `rd_data` is zero whenever `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, two beats per command period |
| rst_n | input | 1 | Synchronous active-low reset |
| kphase | input | 1 | High on command beats, low on the beats between them |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Burst address |
| wdata | input | LANES*LANE_W | Write data, one word per beat |
| be_n | input | LANES | Active-low byte-lane write enables, one per 9-bit lane |
| rd_data | output | LANES*LANE_W | Read data, zero when not valid |
| rd_valid | output | 1 | High during the four read data beats |

## Verification
Four properties are checked on every cycle. No port accepts two commands on back-to-back command edges. A queued burst waits only in the last beat of the running one. A read burst, once it rises, stays valid for four beats. The read bus is zero whenever it is not valid. The bench's scenarios are the only check of the values themselves. These are the word addressing, lane masking, coherence between a read and a write in flight, and the rejection of strobes on half-period beats. For these the bench compares the outputs on every beat with a behavioural model driven from the same stimulus.

// File: rtl/sq4_pkg.sv
// Shared types for the burst-of-four split-port SRAM.
package sq4_pkg;
    // Command loaded at the most recent command edge
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } sq4_cmd_t;

    localparam int BURST_LEN = 4;
    localparam int BEAT_W    = 2;
endpackage

// File: rtl/sq4_cmd_ctrl.sv
// Command acceptance. It decides, at each command edge, whether a read or a
// write starts, based on the strobes and the command loaded on the previous
// command edge. Assumes kphase alternates 1,0,1,0 on consecutive beats.
module sq4_cmd_ctrl
    import sq4_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kphase,
    input  logic rd_n,
    input  logic wr_n,
    output logic rd_go,
    output logic wr_go
);
    sq4_cmd_t last_q;

    // Start decisions for this beat
    always_comb begin
        rd_go = kphase && !rd_n && (last_q != CMD_READ);
        wr_go = kphase && !wr_n && rd_n && (last_q != CMD_WRITE);
    end

    // Remember what this command edge loaded (ignored and deselect load idle)
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= CMD_IDLE;
        else if (kphase)
            last_q <= rd_go ? CMD_READ : (wr_go ? CMD_WRITE : CMD_IDLE);
    end

    // R3: two reads are never accepted on consecutive command edges
    p_rd_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> ##1 !rd_go);

    // R4: two writes are never accepted on consecutive command edges
    p_wr_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> ##1 !wr_go);
endmodule

// File: rtl/sq4_burst_seq.sv
// Burst sequencer for one port. A start records the burst address as
// pending. The burst runs four beats, either from the next beat when idle or
// directly after the current burst's last beat. Assumes starts arrive only
// on command edges and at most every second command edge.
module sq4_burst_seq
    import sq4_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int WORD_W = ADDR_W + BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              active,
    output logic [WORD_W-1:0] word
);
    logic              busy_q, pend_q;
    logic [BEAT_W-1:0] beat_q;
    logic [ADDR_W-1:0] cur_q, pend_addr_q;
    logic              load;

    // A pending burst is taken up when idle or after the last beat
    assign load = pend_q && (!busy_q || (beat_q == BEAT_W'(BURST_LEN - 1)));

    // Track the pending request, the running burst and its beat index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            pend_q      <= 1'b0;
            beat_q      <= '0;
            cur_q       <= '0;
            pend_addr_q <= '0;
        end else begin
            if (busy_q)
                beat_q <= beat_q + 1'b1;
            if (busy_q && beat_q == BEAT_W'(BURST_LEN - 1) && !pend_q)
                busy_q <= 1'b0;
            if (load) begin
                busy_q <= 1'b1;
                beat_q <= '0;
                cur_q  <= pend_addr_q;
                pend_q <= 1'b0;
            end
            if (start) begin
                pend_q      <= 1'b1;
                pend_addr_q <= addr;
            end
        end
    end

    assign active = busy_q;
    assign word   = {cur_q, beat_q};

    // R9: a queued burst only waits while the running one is in its last beat
    p_queue_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && pend_q) |-> (beat_q == BEAT_W'(BURST_LEN - 1)));

    // R9: a start never lands on the edge that takes up a pending burst
    p_start_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !load);
endmodule

// File: rtl/sq4_array.sv
// Register storage split into byte lanes. There is one write port with
// per-lane active-low enables and one combinational read port. Cleared by
// reset.
module sq4_array #(
    parameter int WORD_W = 5,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int WORDS  = 1 << WORD_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  be_n,
    input  logic [WORD_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [WORDS];

        // Clear on reset, otherwise store this lane when enabled
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < WORDS; i++)
                    mem[i] <= '0;
            end else if (we && !be_n[l]) begin
                mem[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/sq4_sram.sv
// Burst-of-four split-port SRAM top. Command acceptance drives one burst
// sequencer per port. The write sequencer stores wdata beat by beat and the
// read sequencer loads the registered read bus. Assumes kphase alternates
// and is 1 on the first beat after reset.
module sq4_sram
    import sq4_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int WORD_W = ADDR_W + BEAT_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kphase,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  be_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic              rd_go, wr_go;
    logic              rd_act, wr_act;
    logic [WORD_W-1:0] rd_word, wr_word;
    logic [DATA_W-1:0] arr_q;

    sq4_cmd_ctrl u_cmd (
        .clk(clk), .rst_n(rst_n), .kphase(kphase),
        .rd_n(rd_n), .wr_n(wr_n), .rd_go(rd_go), .wr_go(wr_go)
    );

    sq4_burst_seq #(.ADDR_W(ADDR_W)) u_rseq (
        .clk(clk), .rst_n(rst_n), .start(rd_go), .addr(addr),
        .active(rd_act), .word(rd_word)
    );

    sq4_burst_seq #(.ADDR_W(ADDR_W)) u_wseq (
        .clk(clk), .rst_n(rst_n), .start(wr_go), .addr(addr),
        .active(wr_act), .word(wr_word)
    );

    sq4_array #(.WORD_W(WORD_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .we(wr_act), .waddr(wr_word),
        .wdata(wdata), .be_n(be_n), .raddr(rd_word), .rdata(arr_q)
    );

    // Register the read beat, zero when no read burst is running
    always_ff @(posedge clk) begin
        if (!rst_n || !rd_act) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b1;
            rd_data  <= arr_q;
        end
    end

    // R11: the read bus is quiet whenever it is not valid
    p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    // R7: a read burst, once it starts, stays valid for four beats
    p_four_beats_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |=> rd_valid ##1 rd_valid ##1 rd_valid);
endmodule

// File: tb/sim_sq4_sram.sv
// Bench: a behavioural model schedules read and write beats by edge number
// and is compared with the outputs on every beat.
module sim_sq4_sram;
    localparam int ADDR_W = 3;
    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int DATA_W = LANES * LANE_W;
    localparam int WORDS  = 4 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              kphase = 1'b1;
    logic              rd_n = 1'b1, wr_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [LANES-1:0]  be_n = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;

    int    checks = 0, failures = 0;
    bit    done = 0, started = 0, rand_be = 0;
    string cur_req = "R11";

    sq4_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .kphase(kphase), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .be_n(be_n),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #5 clk = ~clk;

    // Reference model
    logic [DATA_W-1:0] mem_m [WORDS];
    int  rd_at [int];
    int  wr_at [int];
    int  edge_n = 0;
    int  last_m = 0;              // 0 idle, 1 read, 2 write
    logic              exp_v = 0;
    logic [DATA_W-1:0] exp_d = '0;

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            foreach (mem_m[i]) mem_m[i] = '0;
            rd_at.delete();
            wr_at.delete();
            last_m = 0;
            exp_v  = 0;
            exp_d  = '0;
        end else begin
            if (kphase) begin
                if (!rd_n && last_m != 1) begin
                    for (int i = 0; i < 4; i++) rd_at[edge_n + 2 + i] = addr * 4 + i;
                    last_m = 1;
                end else if (!wr_n && rd_n && last_m != 2) begin
                    for (int i = 0; i < 4; i++) wr_at[edge_n + 2 + i] = addr * 4 + i;
                    last_m = 2;
                end else begin
                    last_m = 0;
                end
            end
            if (rd_at.exists(edge_n)) begin
                exp_v = 1;
                exp_d = mem_m[rd_at[edge_n]];
                rd_at.delete(edge_n);
            end else begin
                exp_v = 0;
                exp_d = '0;
            end
            if (wr_at.exists(edge_n)) begin
                for (int l = 0; l < LANES; l++)
                    if (!be_n[l])
                        mem_m[wr_at[edge_n]][l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
                wr_at.delete(edge_n);
            end
        end
        edge_n++;
    end

    // Compare every beat, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (rd_valid !== exp_v || rd_data !== exp_d) begin
                failures++;
                $display("FAIL %s: rd_valid=%0b rd_data=%h expected rd_valid=%0b rd_data=%h at edge %0d",
                         cur_req, rd_valid, rd_data, exp_v, exp_d, edge_n);
            end
        end
    end

    // One beat of stimulus
    task automatic beat(input logic kph, input logic rn, input logic wn, input int a);
        @(negedge clk);
        kphase = kph;
        rd_n   = rn;
        wr_n   = wn;
        addr   = ADDR_W'(a);
        wdata  = DATA_W'($urandom);
        be_n   = rand_be ? LANES'($urandom) : '0;
    endtask

    // One command period; strobes on the half beat default to high
    task automatic kcyc(input logic rn, input logic wn, input int a,
                        input logic rnb = 1'b1, input logic wnb = 1'b1);
        beat(1'b1, rn, wn, a);
        beat(1'b0, rnb, wnb, a);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) kcyc(1'b1, 1'b1, 0);
    endtask

    initial begin
        repeat (3) beat(1'b1, 1'b1, 1'b1, 0);
        @(negedge clk);
        rst_n = 1'b1;
        kphase = 1'b1;
        cur_req = "R11"; idle(3);                                 // reset state
        cur_req = "R6";  kcyc(1, 0, 2); idle(3); kcyc(0, 1, 2); idle(4);
        cur_req = "R5";  kcyc(1, 0, 5); idle(3); kcyc(0, 1, 5); idle(4);
        cur_req = "R8";  rand_be = 1; kcyc(1, 0, 3); idle(3); rand_be = 0;
                         kcyc(0, 1, 3); idle(4);
        cur_req = "R3";  kcyc(0, 1, 2); kcyc(0, 1, 2); kcyc(0, 1, 5); idle(5);
        cur_req = "R4";  kcyc(1, 0, 6); kcyc(1, 0, 7); kcyc(0, 0, 6); idle(3);
                         kcyc(0, 1, 7); idle(4);
        cur_req = "R1";  kcyc(1, 1, 1, 1'b0, 1'b1); kcyc(1, 1, 1, 1'b1, 1'b0); idle(2);
                         kcyc(0, 1, 1); idle(4);
        cur_req = "R2";  kcyc(0, 1, 4); kcyc(1, 1, 4); kcyc(0, 1, 4); idle(6);
        cur_req = "R10"; kcyc(1, 0, 4); kcyc(0, 1, 4); idle(4);
                         rand_be = 1; kcyc(1, 0, 4); kcyc(0, 1, 4); rand_be = 0; idle(4);
        cur_req = "R7";  kcyc(0, 1, 0); kcyc(1, 1, 0); kcyc(0, 1, 6); idle(5);
        cur_req = "R9";  for (int i = 0; i < 12; i++) kcyc(i % 2 == 0, i % 2 == 1, i % 8);
                         idle(4);
                         rand_be = 1;
                         for (int i = 0; i < 300; i++)
                             kcyc(1'($urandom), 1'($urandom), int'($urandom % 8),
                                  1'($urandom), 1'($urandom));
                         rand_be = 0; idle(5);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule